// File: doc/BRIEF.md
# Auxiliary Memory Region Selector

This block sits beside the CPU address bus of an 8-bit system that has two 48K-plus RAM banks, a main one and an auxiliary one. For every address it says, for a read and separately for a write, which of the two banks the access should reach. The control state is four flags:

- a zero-page/stack flag for the bottom 512 bytes;
- a read-steering flag for the general RAM area;
- a write-steering flag for the general RAM area;
- a display-window override flag.

Software changes each flag by writing to one address of a pair in the C000 I/O page. The even address of the pair clears the flag and the odd address sets it.

While the override flag is on, the two display windows are steered by a display-page flag instead of the read and write flags. The windows are 0400–07FF and 2000–3FFF. The display-page flag is kept by the video logic and arrives on an input pin. Its effect on the two windows is immediate.

The bank selects are combinational in the current address and the current flags. A switch write takes effect from the cycle after the write strobe. A read strobe on one of five status addresses returns one flag in bit 7 of a status byte. Addresses at C000 and above are reported as "not RAM", and both bank selects are then low.

Top module: `aux_bank_sel`

## Requirements
- R1: After reset all four flags are 0, so every address below C000 selects main RAM (rd_aux_o=0, wr_aux_o=0), and every status read returns 0x00.
- R2: A write strobe at C000/C001 loads the override flag, at C002/C003 the read-steering flag, at C004/C005 the write-steering flag, and at C008/C009 the zero-page flag. The new value is address bit 0, and it is visible from the next clock cycle. A read strobe at these addresses leaves the flags unchanged.
- R3: For addresses 0000–01FF, rd_aux_o and wr_aux_o both equal the zero-page flag.
- R4: For 0200–BFFF outside the display windows, rd_aux_o equals the read-steering flag and wr_aux_o equals the write-steering flag, independently of each other.
- R5: While the override flag is 1, rd_aux_o and wr_aux_o both equal page2_i for addresses in 0400–07FF and 2000–3FFF, whatever the read and write steering flags hold.
- R6: While the override flag is 0, the two display windows follow the R4 rules.
- R7: A change of page2_i changes the window selects in the same cycle, with no clock edge needed.
- R8: While rd_i is 1 and addr_i is C013, C014, C016, C018 or C01C, stat_hit_o is 1 and stat_data_o bit 7 holds, in that order, the read-steering flag, the write-steering flag, the zero-page flag, the override flag and page2_i. Bits 6..0 are 0. At every other time stat_hit_o is 0 and stat_data_o is 0x00.
- R9: For addresses C000–FFFF, io_space_o is 1 and both bank selects are 0. Below C000, io_space_o is 0.
- R10: Write strobes at other I/O addresses leave all four flags unchanged. Examples are C006, C010 and C055.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | CPU address of the current access |
| rd_i | input | 1 | Read strobe for the current cycle |
| wr_i | input | 1 | Write strobe for the current cycle |
| page2_i | input | 1 | Display-page flag from the video logic |
| rd_aux_o | output | 1 | A read at addr_i goes to auxiliary RAM |
| wr_aux_o | output | 1 | A write at addr_i goes to auxiliary RAM |
| io_space_o | output | 1 | addr_i is not RAM (C000 and above) |
| stat_hit_o | output | 1 | The current read is a flag status read |
| stat_data_o | output | 8 | Status byte, flag in bit 7 |

## Verification
The main function is tried in three ways.

First, each region (zero page, both display windows, general RAM, I/O) is probed under several flag combinations. One combination has the read flag set and the write flag clear, and another has the reverse. These probes tell apart a design that ties the read select to the write select, and one that confuses the two steering flags.

Second, the display windows are probed with the override flag on and off, and page2_i is toggled in the same cycle as a probe. This separates window routing by page from routing by the steering flags, and it catches any registered delay on the page path.

Third, each switch pair is written, reads are made at switch addresses, and writes are made at unrelated I/O addresses. The status addresses are then read back to show which flags moved and which did not.

// File: rtl/aux_bank_pkg.sv
package aux_bank_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Region boundaries (first address of the next region)
    localparam logic [ADDR_W-1:0] ZP_END   = 16'h0200;
    localparam logic [ADDR_W-1:0] TXT_LO   = 16'h0400;
    localparam logic [ADDR_W-1:0] TXT_END  = 16'h0800;
    localparam logic [ADDR_W-1:0] GFX_LO   = 16'h2000;
    localparam logic [ADDR_W-1:0] GFX_END  = 16'h4000;
    localparam logic [ADDR_W-1:0] IO_LO    = 16'hC000;

    // Switch pair base addresses (bit 0 carries the new value)
    localparam logic [ADDR_W-1:0] SW_OVR   = 16'hC000;
    localparam logic [ADDR_W-1:0] SW_RDS   = 16'hC002;
    localparam logic [ADDR_W-1:0] SW_WRS   = 16'hC004;
    localparam logic [ADDR_W-1:0] SW_ZPG   = 16'hC008;

    // Status addresses
    localparam logic [ADDR_W-1:0] ST_RDS   = 16'hC013;
    localparam logic [ADDR_W-1:0] ST_WRS   = 16'hC014;
    localparam logic [ADDR_W-1:0] ST_ZPG   = 16'hC016;
    localparam logic [ADDR_W-1:0] ST_OVR   = 16'hC018;
    localparam logic [ADDR_W-1:0] ST_PAGE  = 16'hC01C;

    typedef struct packed {
        logic win_ovr;   // display windows follow the page flag
        logic rd_steer;  // general reads go to auxiliary RAM
        logic wr_steer;  // general writes go to auxiliary RAM
        logic zp_alt;    // zero page and stack in auxiliary RAM
    } bank_flags_t;

    typedef enum logic [1:0] {
        RGN_ZP   = 2'd0,
        RGN_WIN  = 2'd1,
        RGN_GEN  = 2'd2,
        RGN_IO   = 2'd3
    } region_t;

endpackage

// File: rtl/aux_switch_regs.sv
module aux_switch_regs
    import aux_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output bank_flags_t       flags_q
);

    localparam logic [ADDR_W-1:0] PAIR_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] pair_base;
    logic              new_val;
    logic              sw_hit;
    bank_flags_t       flags_d;

    always_comb begin
        pair_base = addr_i & PAIR_MASK;
        new_val   = addr_i[0];
        sw_hit    = 1'b0;
        flags_d   = flags_q;
        if (wr_i) begin
            if (pair_base == SW_OVR) begin
                flags_d.win_ovr  = new_val;
                sw_hit           = 1'b1;
            end else if (pair_base == SW_RDS) begin
                flags_d.rd_steer = new_val;
                sw_hit           = 1'b1;
            end else if (pair_base == SW_WRS) begin
                flags_d.wr_steer = new_val;
                sw_hit           = 1'b1;
            end else if (pair_base == SW_ZPG) begin
                flags_d.zp_alt   = new_val;
                sw_hit           = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // R10 and R2: the flags move only on a switch write strobe
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_hit |=> $stable(flags_q));

    // R2: a read-steering pair write loads address bit 0
    a_r2_rd_steer_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && pair_base == SW_RDS) |=> flags_q.rd_steer == $past(addr_i[0]));

    // R2: an override pair write loads address bit 0
    a_r2_ovr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && pair_base == SW_OVR) |=> flags_q.win_ovr == $past(addr_i[0]));

endmodule

// File: rtl/aux_region_decode.sv
module aux_region_decode
    import aux_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  bank_flags_t       flags_i,
    input  logic              page2_i,
    output logic              rd_aux_o,
    output logic              wr_aux_o,
    output logic              io_space_o
);

    region_t region;

    always_comb begin
        if (addr_i >= IO_LO)
            region = RGN_IO;
        else if (addr_i < ZP_END)
            region = RGN_ZP;
        else if ((addr_i >= TXT_LO && addr_i < TXT_END) ||
                 (addr_i >= GFX_LO && addr_i < GFX_END))
            region = RGN_WIN;
        else
            region = RGN_GEN;
    end

    always_comb begin
        rd_aux_o   = 1'b0;
        wr_aux_o   = 1'b0;
        io_space_o = 1'b0;
        unique case (region)
            RGN_ZP: begin
                rd_aux_o = flags_i.zp_alt;
                wr_aux_o = flags_i.zp_alt;
            end
            RGN_WIN: begin
                if (flags_i.win_ovr) begin
                    rd_aux_o = page2_i;
                    wr_aux_o = page2_i;
                end else begin
                    rd_aux_o = flags_i.rd_steer;
                    wr_aux_o = flags_i.wr_steer;
                end
            end
            RGN_GEN: begin
                rd_aux_o = flags_i.rd_steer;
                wr_aux_o = flags_i.wr_steer;
            end
            RGN_IO: io_space_o = 1'b1;
            default: io_space_o = 1'b1;
        endcase
    end

    // R9: I/O space never selects auxiliary RAM
    a_r9_io_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
        io_space_o |-> (!rd_aux_o && !wr_aux_o));

    // R3: zero page steers read and write alike
    a_r3_zp_same: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i < ZP_END) |-> (rd_aux_o == wr_aux_o));

    // R5: override routes windows by page
    a_r5_win_page: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i.win_ovr && addr_i >= TXT_LO && addr_i < TXT_END)
            |-> (rd_aux_o == page2_i && wr_aux_o == page2_i));

endmodule

// File: rtl/aux_status_mux.sv
module aux_status_mux
    import aux_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  bank_flags_t       flags_i,
    input  logic              page2_i,
    output logic              stat_hit_o,
    output logic [DATA_W-1:0] stat_data_o
);

    logic flag_bit;

    always_comb begin
        stat_hit_o = 1'b0;
        flag_bit   = 1'b0;
        if (rd_i) begin
            stat_hit_o = 1'b1;
            if      (addr_i == ST_RDS)  flag_bit = flags_i.rd_steer;
            else if (addr_i == ST_WRS)  flag_bit = flags_i.wr_steer;
            else if (addr_i == ST_ZPG)  flag_bit = flags_i.zp_alt;
            else if (addr_i == ST_OVR)  flag_bit = flags_i.win_ovr;
            else if (addr_i == ST_PAGE) flag_bit = page2_i;
            else                        stat_hit_o = 1'b0;
        end
        stat_data_o = {flag_bit, {(DATA_W-1){1'b0}}};
    end

    // R8: low bits of the status byte are always zero, and no data without a hit
    a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_data_o[DATA_W-2:0] == '0) && (stat_hit_o || stat_data_o == '0));

endmodule

// File: rtl/aux_bank_sel.sv
module aux_bank_sel
    import aux_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              page2_i,
    output logic              rd_aux_o,
    output logic              wr_aux_o,
    output logic              io_space_o,
    output logic              stat_hit_o,
    output logic [7:0]        stat_data_o
);

    bank_flags_t flags_q;

    aux_switch_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .flags_q (flags_q)
    );

    aux_region_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .flags_i    (flags_q),
        .page2_i    (page2_i),
        .rd_aux_o   (rd_aux_o),
        .wr_aux_o   (wr_aux_o),
        .io_space_o (io_space_o)
    );

    aux_status_mux u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .rd_i        (rd_i),
        .flags_i     (flags_q),
        .page2_i     (page2_i),
        .stat_hit_o  (stat_hit_o),
        .stat_data_o (stat_data_o)
    );

    // R7: the page input alone moves the window selects, with no clock edge
    a_r7_page_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.win_ovr && addr_i >= 16'h2000 && addr_i < 16'h4000)
            |-> (rd_aux_o == page2_i));

endmodule

// File: tb/aux_bank_sel_test.sv
module aux_bank_sel_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = 16'h0000;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic        page2_i = 1'b0;
    logic        rd_aux_o, wr_aux_o, io_space_o, stat_hit_o;
    logic [7:0]  stat_data_o;

    aux_bank_sel uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
        .page2_i(page2_i), .rd_aux_o(rd_aux_o), .wr_aux_o(wr_aux_o),
        .io_space_o(io_space_o), .stat_hit_o(stat_hit_o), .stat_data_o(stat_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string      tag;
        logic       rd_aux;
        logic       wr_aux;
        logic       io;
        logic       hit;
        logic [7:0] data;
    } exp_t;

    exp_t q[$];
    event probe_ev;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    // Bench model of the flags
    logic m_ovr = 0, m_rds = 0, m_wrs = 0, m_zpg = 0;

    function automatic exp_t model(input logic [15:0] a, input logic rd, input string tag);
        exp_t e;
        e.tag = tag; e.rd_aux = 0; e.wr_aux = 0; e.io = 0; e.hit = 0; e.data = 8'h00;
        if (a >= 16'hC000) e.io = 1;
        else if (a < 16'h0200) begin e.rd_aux = m_zpg; e.wr_aux = m_zpg; end
        else if (((a >= 16'h0400 && a < 16'h0800) || (a >= 16'h2000 && a < 16'h4000)) && m_ovr) begin
            e.rd_aux = page2_i; e.wr_aux = page2_i;
        end else begin e.rd_aux = m_rds; e.wr_aux = m_wrs; end
        if (rd) begin
            e.hit = 1;
            case (a)
                16'hC013: e.data = {m_rds, 7'b0};
                16'hC014: e.data = {m_wrs, 7'b0};
                16'hC016: e.data = {m_zpg, 7'b0};
                16'hC018: e.data = {m_ovr, 7'b0};
                16'hC01C: e.data = {page2_i, 7'b0};
                default:  e.hit = 0;
            endcase
        end
        return e;
    endfunction

    task automatic probe(input logic [15:0] a, input logic rd, input logic pg, input string tag);
        @(negedge clk);
        addr_i = a; rd_i = rd; wr_i = 0; page2_i = pg;
        q.push_back(model(a, rd, tag));
        #1 -> probe_ev;
        #1;
    endtask

    task automatic sw_write(input logic [15:0] a);
        @(negedge clk);
        addr_i = a; rd_i = 0; wr_i = 1;
        @(negedge clk);
        wr_i = 0;
        case (a & 16'hFFFE)
            16'hC000: m_ovr = a[0];
            16'hC002: m_rds = a[0];
            16'hC004: m_wrs = a[0];
            16'hC008: m_zpg = a[0];
            default: ;
        endcase
    endtask

    task automatic rd_strobe(input logic [15:0] a);
        @(negedge clk);
        addr_i = a; rd_i = 1; wr_i = 0;
        @(negedge clk);
        rd_i = 0;
    endtask

    // Monitor: pop and compare
    initial begin
        forever begin
            @probe_ev;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rd_aux_o !== e.rd_aux || wr_aux_o !== e.wr_aux || io_space_o !== e.io ||
                    stat_hit_o !== e.hit || stat_data_o !== e.data) begin
                    fails++;
                    $display("FAIL %s: got rd=%b wr=%b io=%b hit=%b data=%h expected rd=%b wr=%b io=%b hit=%b data=%h",
                             e.tag, rd_aux_o, wr_aux_o, io_space_o, stat_hit_o, stat_data_o,
                             e.rd_aux, e.wr_aux, e.io, e.hit, e.data);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        probe(16'h0100, 0, 0, "R1 zero page after reset");
        probe(16'h0500, 0, 0, "R1 window after reset");
        probe(16'h8000, 0, 0, "R1 general after reset");
        probe(16'hC016, 1, 0, "R1 status after reset");
        // R2/R3: zero page flag
        sw_write(16'hC009);
        probe(16'h0080, 0, 0, "R3 zero page aux");
        probe(16'h0300, 0, 0, "R3 zero page flag not in general");
        // R2/R4: read steering only
        sw_write(16'hC003);
        probe(16'h8000, 0, 0, "R4 read aux write main");
        probe(16'h0500, 0, 0, "R6 window follows read flag");
        sw_write(16'hC005);
        probe(16'h2000, 0, 0, "R6 window both aux");
        sw_write(16'hC002);
        probe(16'hBFFF, 0, 0, "R4 write aux read main");
        // R5: override with page 0
        sw_write(16'hC001);
        probe(16'h0400, 0, 0, "R5 text window page0");
        probe(16'h3FFF, 0, 0, "R5 graphics window page0");
        probe(16'h4000, 0, 0, "R5 outside window unaffected");
        // R7: page change same cycle
        probe(16'h07FF, 0, 1, "R7 page1 immediate");
        probe(16'h07FF, 0, 0, "R7 page0 immediate");
        // R8: status reads
        probe(16'hC018, 1, 1, "R8 override status");
        probe(16'hC013, 1, 1, "R8 read steer status");
        probe(16'hC01C, 1, 1, "R8 page status");
        probe(16'hC014, 1, 1, "R8 write steer status");
        probe(16'hC016, 1, 1, "R8 zero page status");
        probe(16'hC015, 1, 1, "R8 non status read");
        probe(16'hC018, 0, 1, "R8 no hit without strobe");
        // R9: I/O space
        probe(16'hC000, 0, 1, "R9 io low edge");
        probe(16'hFFFF, 0, 1, "R9 io top");
        probe(16'hBFFF, 0, 1, "R9 just below io");
        // R10 and R2 read-does-not-switch
        sw_write(16'hC006);
        sw_write(16'hC010);
        sw_write(16'hC055);
        rd_strobe(16'hC000);
        rd_strobe(16'hC004);
        probe(16'hC018, 1, 1, "R10 override unchanged");
        probe(16'hC014, 1, 1, "R2 read strobe no switch");
        probe(16'hC013, 1, 1, "R10 read steer unchanged");
        // R6: override off, windows follow steering again
        sw_write(16'hC000);
        probe(16'h0400, 0, 1, "R6 window read main write aux");
        sw_write(16'hC008);
        probe(16'h0000, 0, 1, "R3 zero page main");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule